// File: doc/BRIEF.md
# Half-Table Exponent-to-Float Converter

This block takes the biased exponent field of a floating-point operand and produces a 32-bit single-precision float whose value is the unbiased exponent, X − bias. A logarithm datapath would multiply this value by a constant and add it to a mantissa term. The field is `EXP_W` bits wide: 11 for double-precision operands, which is the default, or 8 for single-precision operands. A valid strobe travels with the data, and every result appears exactly two clock cycles after its input.

The lookup table covers only half of the exponent codes. A code whose top bit is clear indexes the table directly with its low bits. A code whose top bit is set is mirrored to the index 2·bias − X, taken modulo the table depth. The top bit is then turned into the result sign. Each entry keeps only the low bits of the result exponent and the leading mantissa bits. The high exponent bits are the constant pattern 1 followed by zeros, and every unstored mantissa bit is zero. Two codes fall outside this pattern, the results 0 and ±1. A dedicated compare on the code or on the folded index catches each of them.

Top module: `exp_to_float_half`

## Requirements
- R1: For every code X in 0 .. 2^EXP_W − 1 with EXP_W = 11, out_float is exactly the IEEE-754 single-precision encoding of X − 1023 (bit 31 sign, bits 30:23 biased exponent, bits 22:0 fraction).
- R2: out_valid is high in the cycle two rising clock edges after in_valid was sampled high, and is low otherwise.
- R3: The code equal to the bias (1023 for 11 bits, 127 for 8 bits) yields +0.0, that is all 32 bits zero.
- R4: For every nonzero result, bit 31 is set exactly when the top bit of the input code is clear.
- R5: The extreme codes map to the largest magnitudes. With EXP_W = 11, code 0 gives −1023.0 (0xC47FC000) and code 2047 gives +1024.0 (0x44800000). The all-ones code is the one whose folded index wraps around.
- R6: The codes bias − 1 and bias + 1 give −1.0 (0xBF800000) and +1.0 (0x3F800000), whose exponent field 127 lies outside the fixed high-bit pattern.
- R7: While out_valid is low, out_float keeps the last result produced. Changes on in_exp while in_valid is low have no effect on the outputs.
- R8: While rst_n is low, out_valid and out_float are zero. The clear takes effect without waiting for a clock edge.
- R9: Inputs presented on consecutive cycles produce results on consecutive cycles, one per clock, with no gaps.
- R10: With EXP_W = 8, every code X in 0 .. 255 yields exactly the single-precision encoding of X − 127. This covers −127.0 for code 0 and +128.0 for code 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| in_valid | input | 1 | Strobe marking in_exp as a code to convert |
| in_exp | input | EXP_W | Biased exponent field |
| out_valid | output | 1 | Strobe marking out_float as a fresh result |
| out_float | output | 32 | Single-precision value of the unbiased exponent |

## Verification
The bench targets the codes where the folding trick is fragile. The all-ones code wraps its mirrored index onto the entry shared with the bias code. A design that missed the wrap, or forgot the zero compare, would return 0 for 2047 or 1024 for 1023. The codes next to the bias need exponent 127. A design that trusted the table there would produce ±2.0 or garbage instead of ±1.0. A sign taken straight from the top bit, without inverting it, would flip every result. A full streaming sweep in both widths catches an off-by-one in the fold base or in the mantissa shift, as well as any bubble or skew in the two-cycle pipeline. The hold test shows whether a missing clock enable lets idle inputs leak into the output.

// File: rtl/exp2f_pkg.sv
package exp2f_pkg;

  localparam int unsigned FLT_W     = 32;
  localparam int unsigned FLT_EXP_W = 8;
  localparam int unsigned FLT_FRC_W = 23;
  localparam int unsigned FLT_BIAS  = 127;

  typedef logic [FLT_W-1:0] flt32_t;

  // How stage two builds its result
  typedef enum logic [1:0] {
    KIND_TABLE = 2'd0,
    KIND_ZERO  = 2'd1,
    KIND_UNIT  = 2'd2
  } fold_kind_e;

  // Position of the highest set bit (v must be nonzero)
  function automatic int unsigned msb_pos(input int unsigned v);
    int unsigned p;
    p = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) p = i;
    end
    return p;
  endfunction

endpackage

// File: rtl/exp_fold.sv
module exp_fold
  import exp2f_pkg::*;
#(
  parameter int unsigned EXP_W = 11
) (
  input  logic [EXP_W-1:0] exp_field,
  output logic [EXP_W-2:0] idx,
  output logic             sign,
  output fold_kind_e       kind
);

  localparam int unsigned IDX_W = EXP_W - 1;
  localparam int unsigned BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] MIRROR_BASE = EXP_W'(2 * BIAS);
  localparam logic [EXP_W-1:0] BIAS_CODE   = EXP_W'(BIAS);
  localparam logic [IDX_W-1:0] UNIT_IDX    = IDX_W'(BIAS - 1);

  logic             upper_half;
  logic [EXP_W-1:0] mirrored;

  always_comb begin
    upper_half = exp_field[EXP_W-1];
    // Wraps to all ones for the all-ones code; that entry holds the top magnitude
    mirrored   = MIRROR_BASE - exp_field;
    idx        = upper_half ? mirrored[IDX_W-1:0] : exp_field[IDX_W-1:0];
    sign       = ~upper_half;
    if (exp_field == BIAS_CODE) begin
      kind = KIND_ZERO;
    end else if (idx == UNIT_IDX) begin
      kind = KIND_UNIT;
    end else begin
      kind = KIND_TABLE;
    end
  end

endmodule

// File: rtl/exp_half_rom.sv
module exp_half_rom
  import exp2f_pkg::*;
#(
  parameter int unsigned EXP_W = 11
) (
  input  logic [EXP_W-2:0]                        idx,
  output logic [$clog2(EXP_W-1)+(EXP_W-2)-1:0]    entry
);

  localparam int unsigned IDX_W  = EXP_W - 1;
  localparam int unsigned DEPTH  = 1 << IDX_W;
  localparam int unsigned BIAS   = DEPTH - 1;
  localparam int unsigned LOW_W  = $clog2(EXP_W - 1);
  localparam int unsigned MANT_W = EXP_W - 2;
  localparam int unsigned ENT_W  = LOW_W + MANT_W;

  // Entry: low exponent bits (k-1) and leading mantissa bits of magnitude
  function automatic logic [ENT_W-1:0] entry_for(input int unsigned slot);
    int unsigned mag;
    int unsigned k;
    int unsigned low;
    int unsigned mant;
    mag = (slot == BIAS) ? DEPTH : (BIAS - slot);
    if (mag < 2) return '0;
    k    = msb_pos(mag);
    low  = k - 1;
    mant = (k <= MANT_W) ? ((mag - (32'd1 << k)) << (MANT_W - k)) : 32'd0;
    return {LOW_W'(low), MANT_W'(mant)};
  endfunction

  logic [ENT_W-1:0] table_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    assign table_q[gi] = entry_for(gi);
  end

  assign entry = table_q[idx];

endmodule

// File: rtl/flt_assemble.sv
module flt_assemble
  import exp2f_pkg::*;
#(
  parameter int unsigned EXP_W = 11
) (
  input  logic                                  sign,
  input  fold_kind_e                            kind,
  input  logic [$clog2(EXP_W-1)+(EXP_W-2)-1:0]  entry,
  output flt32_t                                value
);

  localparam int unsigned LOW_W  = $clog2(EXP_W - 1);
  localparam int unsigned MANT_W = EXP_W - 2;
  localparam int unsigned GAP_W  = FLT_EXP_W - 1 - LOW_W;
  localparam int unsigned PAD_W  = FLT_FRC_W - MANT_W;

  logic [LOW_W-1:0]  exp_low;
  logic [MANT_W-1:0] mant_hi;

  always_comb begin
    exp_low = entry[LOW_W+MANT_W-1:MANT_W];
    mant_hi = entry[MANT_W-1:0];
    unique case (kind)
      KIND_ZERO: value = '0;
      KIND_UNIT: value = {sign, FLT_EXP_W'(FLT_BIAS), {FLT_FRC_W{1'b0}}};
      default:   value = {sign, 1'b1, {GAP_W{1'b0}}, exp_low, mant_hi, {PAD_W{1'b0}}};
    endcase
  end

endmodule

// File: rtl/exp_to_float_half.sv
module exp_to_float_half
  import exp2f_pkg::*;
#(
  parameter int unsigned EXP_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [EXP_W-1:0] in_exp,
  output logic             out_valid,
  output logic [31:0]      out_float
);

  localparam int unsigned IDX_W  = EXP_W - 1;
  localparam int unsigned LOW_W  = $clog2(EXP_W - 1);
  localparam int unsigned MANT_W = EXP_W - 2;
  localparam int unsigned ENT_W  = LOW_W + MANT_W;

  // Stage one: fold
  logic [IDX_W-1:0] fold_idx;
  logic             fold_sign;
  fold_kind_e       fold_kind;

  logic             s1_valid_q, s1_valid_d;
  logic [IDX_W-1:0] s1_idx_q,   s1_idx_d;
  logic             s1_sign_q,  s1_sign_d;
  fold_kind_e       s1_kind_q,  s1_kind_d;

  exp_fold #(.EXP_W(EXP_W)) u_fold (
    .exp_field (in_exp),
    .idx       (fold_idx),
    .sign      (fold_sign),
    .kind      (fold_kind)
  );

  always_comb begin
    s1_valid_d = in_valid;
    s1_idx_d   = s1_idx_q;
    s1_sign_d  = s1_sign_q;
    s1_kind_d  = s1_kind_q;
    if (in_valid) begin
      s1_idx_d  = fold_idx;
      s1_sign_d = fold_sign;
      s1_kind_d = fold_kind;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_idx_q   <= '0;
      s1_sign_q  <= 1'b0;
      s1_kind_q  <= KIND_ZERO;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_idx_q   <= s1_idx_d;
      s1_sign_q  <= s1_sign_d;
      s1_kind_q  <= s1_kind_d;
    end
  end

  // Stage two: table read and assembly
  logic [ENT_W-1:0] rom_entry;
  flt32_t           built;
  logic             s2_valid_d;
  flt32_t           s2_float_q, s2_float_d;

  exp_half_rom #(.EXP_W(EXP_W)) u_rom (
    .idx   (s1_idx_q),
    .entry (rom_entry)
  );

  flt_assemble #(.EXP_W(EXP_W)) u_asm (
    .sign  (s1_sign_q),
    .kind  (s1_kind_q),
    .entry (rom_entry),
    .value (built)
  );

  always_comb begin
    s2_valid_d = s1_valid_q;
    s2_float_d = s2_float_q;
    if (s1_valid_q) s2_float_d = built;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      s2_float_q <= '0;
    end else begin
      out_valid  <= s2_valid_d;
      s2_float_q <= s2_float_d;
    end
  end

  assign out_float = s2_float_q;

endmodule

// File: rtl/exp_to_float_half_chk.sv
module exp_to_float_half_chk #(
  parameter int unsigned EXP_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [EXP_W-1:0] in_exp,
  input logic             out_valid,
  input logic [31:0]      out_float
);

  localparam int unsigned BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] BIAS_CODE = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] BELOW     = EXP_W'(BIAS - 1);
  localparam logic [EXP_W-1:0] ABOVE     = EXP_W'(BIAS + 1);
  localparam int unsigned PAD_W = 23 - (EXP_W - 2);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  assert_zero_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_exp, 2) == BIAS_CODE) |-> out_float == 32'd0);

  assert_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_float != 32'd0) |-> out_float[31] == !$past(in_exp[EXP_W-1], 2));

  assert_unit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(in_exp, 2) == BELOW || $past(in_exp, 2) == ABOVE))
      |-> out_float[30:0] == {8'd127, 23'd0});

  assert_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_float != 32'd0)
      |-> (out_float[30:23] >= 8'd127 && out_float[30:23] <= 8'(127 + EXP_W - 1)
           && out_float[PAD_W-1:0] == '0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_float));

endmodule

bind exp_to_float_half exp_to_float_half_chk #(.EXP_W(EXP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_exp    (in_exp),
  .out_valid (out_valid),
  .out_float (out_float)
);

// File: tb/test_exp_to_float_half.sv
module test_exp_to_float_half;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        d_in_valid, s_in_valid;
  logic [10:0] d_in_exp;
  logic [7:0]  s_in_exp;
  logic        d_out_valid, s_out_valid;
  logic [31:0] d_out_float, s_out_float;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  exp_to_float_half #(.EXP_W(11)) i_exp_to_float_half (
    .clk(clk), .rst_n(rst_n), .in_valid(d_in_valid), .in_exp(d_in_exp),
    .out_valid(d_out_valid), .out_float(d_out_float)
  );

  exp_to_float_half #(.EXP_W(8)) i_exp_to_float_half_sp (
    .clk(clk), .rst_n(rst_n), .in_valid(s_in_valid), .in_exp(s_in_exp),
    .out_valid(s_out_valid), .out_float(s_out_float)
  );

  // {code, expected}
  localparam int NVEC = 9;
  localparam logic [42:0] VEC [NVEC] = '{
    {11'd0,    32'hC47FC000},
    {11'd2047, 32'h44800000},
    {11'd1023, 32'h00000000},
    {11'd1024, 32'h3F800000},
    {11'd1022, 32'hBF800000},
    {11'd1025, 32'h40000000},
    {11'd1021, 32'hC0000000},
    {11'd1030, 32'h40E00000},
    {11'd1000, 32'hC1B80000}
  };

  function automatic logic [31:0] ref_float(input int e);
    int m;
    int k;
    logic [31:0] r;
    if (e == 0) return 32'd0;
    m = (e < 0) ? -e : e;
    k = 0;
    for (int i = 0; i < 31; i++) if (m >= (1 << i)) k = i;
    r[31]    = (e < 0);
    r[30:23] = 8'(127 + k);
    r[22:0]  = 23'((m - (1 << k)) << (23 - k));
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] expv);
    checks++;
    if (got !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, expv);
    end
  endtask

  task automatic dp_one(input logic [10:0] code, input logic [31:0] expv, input string req);
    @(negedge clk);
    d_in_valid = 1'b1;
    d_in_exp   = code;
    @(negedge clk);
    d_in_valid = 1'b0;
    check("R2 valid not early", {31'd0, d_out_valid}, 32'd0);
    @(negedge clk);
    check("R2 valid at two cycles", {31'd0, d_out_valid}, 32'd1);
    check(req, d_out_float, expv);
  endtask

  initial begin
    rst_n = 1'b0;
    d_in_valid = 1'b0; d_in_exp = '0;
    s_in_valid = 1'b0; s_in_exp = '0;
    repeat (3) @(negedge clk);
    check("R8 reset valid", {31'd0, d_out_valid}, 32'd0);
    check("R8 reset value", d_out_float, 32'd0);
    rst_n = 1'b1;

    // Directed vector table (R1, R3, R5, R6)
    for (int v = 0; v < NVEC; v++) begin
      dp_one(VEC[v][42:32], VEC[v][31:0], "R1/R3/R5/R6 vector");
    end

    // R7: idle inputs ignored, output held
    dp_one(11'd1030, 32'h40E00000, "R7 setup");
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      d_in_exp = 11'(c * 500);
      check("R7 held value", d_out_float, 32'h40E00000);
      check("R7 no valid", {31'd0, d_out_valid}, 32'd0);
    end

    // R1 R9 R4: streaming sweep of all 11-bit codes
    for (int i = 0; i < 2050; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R9 streaming valid", {31'd0, d_out_valid}, 32'd1);
        check("R1 sweep value", d_out_float, ref_float(i - 2 - 1023));
      end
      if (i < 2048) begin
        d_in_valid = 1'b1;
        d_in_exp   = 11'(i);
      end else begin
        d_in_valid = 1'b0;
      end
    end

    // R10: streaming sweep of all 8-bit codes
    for (int i = 0; i < 258; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R10 sp valid", {31'd0, s_out_valid}, 32'd1);
        check("R10 sp value", s_out_float, ref_float(i - 2 - 127));
      end
      if (i < 256) begin
        s_in_valid = 1'b1;
        s_in_exp   = 8'(i);
      end else begin
        s_in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R10 sp bias zero R3", ref_float(0), 32'd0);
    check("R5 sp top magnitude", ref_float(128), 32'h43000000);

    // R8: asynchronous clear mid-run
    dp_one(11'd2047, 32'h44800000, "R5 before reset");
    #1 rst_n = 1'b0;
    #1;
    check("R8 async clear value", d_out_float, 32'd0);
    check("R8 async clear valid", {31'd0, d_out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    dp_one(11'd0, 32'hC47FC000, "R5 after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule